// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register Bank

This block is the digital front end of a sixteen-channel, eight-bit digital-to-analog converter. A host writes to it over a parallel bus with chip select, read/write, an active-low enable strobe, a four-bit channel address and an eight-bit data bus. Each channel has two registers. The input register takes the host data for the addressed channel. The DAC register holds the code that the converter of that channel actually sees. A single active-low load strobe copies every input register into its DAC register at once, so the host can stage new codes on several channels and then change all the outputs together.

All bus inputs are sampled on the register clock. While the enable is low during a write, the addressed input register tracks the data bus. The cycle in which the enable is first sampled high again commits the value that is on the bus. A read with chip select low drives the addressed input register onto the bus. A separate output-enable signal controls the external tri-state pad. An asynchronous active-low reset clears both register ranks.

Top module: `dac_bank_if`

## Requirements
- R1: There are sixteen channels of eight bits each. Address value n (addr_i[3] is the MSB) selects channel n. The DAC register of channel n appears on dac_code_o[8n+7:8n].
- R2: On every clock edge where cs_ni=0, rw_i=0 and en_ni=0, the input register at addr_i takes data_i, so it follows the bus while the enable is low.
- R3: On the clock edge where en_ni is sampled 1 after being sampled 0 on the previous edge, with cs_ni=0 and rw_i=0, data_i is committed into the input register at addr_i.
- R4: On a clock edge with ld_ni=0 and en_ni=0, every DAC register takes the value its input register holds after that edge. This includes a value written on the same edge. On any other edge the DAC registers keep their values.
- R5: data_oe_o is 1 exactly when cs_ni=0 and rw_i=1. It is combinational, with no clock delay. While it is 1, data_o equals the input register at addr_i. While it is 0, data_o is 0.
- R6: When rst_ni is asserted low, all input and DAC registers clear to 0 at once, without waiting for a clock edge, so dac_code_o reads 0.
- R7: While rst_ni is low, write and load activity leaves every register at 0.
- R8: No input register changes on an edge where cs_ni=1 or rw_i=1. This holds even when the enable is toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset of both ranks |
| cs_ni | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| en_ni | input | 1 | Bus enable strobe, active low |
| ld_ni | input | 1 | Global load strobe, active low |
| addr_i | input | 4 | Channel address |
| data_i | input | 8 | Data bus, inbound |
| data_o | output | 8 | Data bus, outbound readback value |
| data_oe_o | output | 1 | Tri-state enable for the data bus pad |
| dac_code_o | output | 128 | Sixteen packed DAC codes, channel 0 in bits 7:0 |

## Verification
The DAC register rank is a port, so a corrupted DAC register shows on dac_code_o in the cycle after the edge that caused it. The input rank is hidden behind the readback path and the load strobe. A bad input register therefore shows only when that channel is read back, which is combinational, or when a later load copies it out. The bench reads back every channel after each write burst, and its random phase issues frequent loads and reads, so that such errors surface within a few cycles. Misrouted addresses show as a wrong channel slice or a wrong readback byte.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  typedef struct packed {
    logic wr;  // input-register write this edge
    logic ld;  // global transfer this edge
    logic rd;  // readback drive
  } bus_ctl_t;
endpackage

// File: rtl/dac_bus_ctrl.sv
module dac_bus_ctrl
  import dac_bank_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     rw_i,
  input  logic     en_ni,
  input  logic     ld_ni,
  output bus_ctl_t ctl_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= en_ni;
  end

  // transparent while en low, plus the commit edge (en sampled high after low)
  always_comb begin
    ctl_o.wr = !cs_ni && !rw_i && (!en_ni || !en_q);
    ctl_o.ld = !ld_ni && !en_ni;
    ctl_o.rd = !cs_ni && rw_i;
  end

  assert_commit_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rw_i && !en_ni) |=> (!cs_ni && !rw_i) |-> ctl_o.wr);
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] inp_o,
  output logic [DATA_W-1:0] dac_o
);
  logic [DATA_W-1:0] inp_q, inp_d, dac_q;

  // bypass: a same-edge write reaches the DAC rank
  assign inp_d = sel_i ? data_i : inp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inp_q <= '0;
      dac_q <= '0;
    end else begin
      inp_q <= inp_d;
      if (ld_i) dac_q <= inp_d;
    end
  end

  assign inp_o = inp_q;
  assign dac_o = dac_q;

  assert_wr_take_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> inp_q == $past(data_i));
  assert_inp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(inp_q));
  assert_load_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> dac_q == inp_q);
  assert_dac_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(dac_q));
endmodule

// File: rtl/dac_read_mux.sv
module dac_read_mux #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [NUM_CH*DATA_W-1:0] bank_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     rd_i,
  output logic [DATA_W-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    if (rd_i)
      for (int i = 0; i < NUM_CH; i++)
        if (addr_i == ADDR_W'(i)) data_o = bank_i[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/dac_bank_if.sv
module dac_bank_if
  import dac_bank_pkg::*;
#(
  parameter  int unsigned NUM_CH = 16,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     rw_i,
  input  logic                     en_ni,
  input  logic                     ld_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [DATA_W-1:0]        data_o,
  output logic                     data_oe_o,
  output logic [NUM_CH*DATA_W-1:0] dac_code_o
);
  bus_ctl_t                 ctl;
  logic [NUM_CH*DATA_W-1:0] inp_flat;

  dac_bus_ctrl u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .rw_i, .en_ni, .ld_ni, .ctl_o(ctl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan #(.DATA_W(DATA_W)) u_ch (
      .clk_i,
      .rst_ni,
      .sel_i (ctl.wr && (addr_i == ADDR_W'(g))),
      .ld_i  (ctl.ld),
      .data_i,
      .inp_o (inp_flat[g*DATA_W +: DATA_W]),
      .dac_o (dac_code_o[g*DATA_W +: DATA_W])
    );
  end

  dac_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .bank_i(inp_flat), .addr_i, .rd_i(ctl.rd), .data_o
  );

  assign data_oe_o = ctl.rd;

  assert_no_wr_on_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rw_i) |=> $stable(inp_flat));
  assert_bus_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
endmodule

// File: tb/dac_bank_if_test.sv
module dac_bank_if_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b1, en_n = 1'b1, ld_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       oe;
  logic [127:0] dac;

  int n_chk = 0, n_fail = 0;

  // reference model state
  int m_inp [16];
  int m_dac [16];
  bit m_en_q;

  dac_bank_if uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .en_ni(en_n), .ld_ni(ld_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe), .dac_code_o(dac)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_inp[i]) begin m_inp[i] = 0; m_dac[i] = 0; end
      m_en_q = 1'b1;
    end else begin
      if (!cs_n && !rw && (!en_n || !m_en_q)) m_inp[addr] = din;
      if (!ld_n && !en_n) foreach (m_dac[i]) m_dac[i] = m_inp[i];
      m_en_q = en_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all ports with the model, after drivers settle
  always @(negedge clk) begin
    #2;
    for (int i = 0; i < 16; i++) chk("R4 dac code", int'(dac[i*8 +: 8]), m_dac[i]);
    chk("R5 output enable", int'(oe), int'(!cs_n && rw));
    chk("R5 readback", int'(dout), (!cs_n && rw) ? m_inp[addr] : 0);
  end

  task automatic idle();
    @(negedge clk); cs_n = 1; rw = 1; en_n = 1; ld_n = 1;
  endtask

  task automatic bus_write(int a, int v);
    @(negedge clk); cs_n = 0; rw = 0; addr = 4'(a); din = 8'(v); en_n = 0;
    @(negedge clk); en_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic read_chk(string tag, int a, int exp);
    @(negedge clk); cs_n = 0; rw = 1; addr = 4'(a); en_n = 1;
    #3 chk(tag, int'(dout), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3 chk("R6 reset clears dac", int'(dac != 0), 0);
    @(negedge clk); rst_n = 1;

    // R1 / R3: distinct value per channel, committed on enable rise
    for (int i = 0; i < 16; i++) bus_write(i, 8'h30 + i * 7);
    for (int i = 0; i < 16; i++) read_chk("R1 R3 channel readback", i, (8'h30 + i * 7) & 8'hff);
    idle();
    #3 chk("R4 no load keeps dac zero", int'(dac != 0), 0);

    // R3 commit captures bus at enable rise (data changed in final low cycle)
    @(negedge clk); cs_n = 0; rw = 0; addr = 4'd9; din = 8'h01; en_n = 0;
    @(negedge clk); din = 8'hC4;
    @(negedge clk); en_n = 1; din = 8'h5A;
    @(negedge clk); cs_n = 1;
    read_chk("R3 commit value", 9, 8'h5A);

    // R2 + R4: transparent write with load held, same-edge bypass
    @(negedge clk); cs_n = 0; rw = 0; addr = 4'd5; din = 8'h11; en_n = 0; ld_n = 0;
    @(negedge clk); #3 chk("R2 R4 follow 1", int'(dac[5*8 +: 8]), 8'h11);
    din = 8'h22;
    @(negedge clk); #3 chk("R2 R4 follow 2", int'(dac[5*8 +: 8]), 8'h22);
    chk("R1 ch9 slice after load", int'(dac[9*8 +: 8]), 8'h5A);
    chk("R1 ch15 slice after load", int'(dac[15*8 +: 8]), (8'h30 + 15 * 7) & 8'hff);
    idle();

    // R4: global load without a write
    bus_write(0, 8'hE7);
    bus_write(15, 8'h3C);
    @(negedge clk); cs_n = 1; en_n = 0; ld_n = 0;
    @(negedge clk); #3 chk("R4 load ch0", int'(dac[7:0]), 8'hE7);
    chk("R1 R4 load ch15", int'(dac[127:120]), 8'h3C);
    idle();

    // R8: enable pulses with cs high, then with rw high
    @(negedge clk); cs_n = 1; rw = 0; addr = 4'd3; din = 8'hFF; en_n = 0;
    @(negedge clk); en_n = 1;
    @(negedge clk); cs_n = 0; rw = 1; en_n = 0;
    @(negedge clk); en_n = 1;
    read_chk("R8 ignored writes", 3, (8'h30 + 3 * 7) & 8'hff);
    idle();

    // R5: bus floats unless cs low and rw high
    @(negedge clk); cs_n = 1; rw = 1;
    #3 chk("R5 oe off cs high", int'(oe), 0);
    chk("R5 data zero cs high", int'(dout), 0);
    @(negedge clk); cs_n = 0; rw = 0; en_n = 1;
    #3 chk("R5 oe off on write", int'(oe), 0);
    idle();

    // R6 / R7: asynchronous reset mid-cycle with write and load active
    @(negedge clk); cs_n = 0; rw = 0; addr = 4'd7; din = 8'hAA; en_n = 0; ld_n = 0;
    #5 rst_n = 0;
    #1 chk("R6 async clear", int'(dac != 0), 0);
    @(negedge clk); #3 chk("R7 reset beats write and load", int'(dac != 0), 0);
    rw = 1; en_n = 1;
    #1 chk("R7 input rank held at zero", int'(dout), 0);
    @(negedge clk); rst_n = 1;
    idle();

    // random traffic checked against the model every cycle
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      cs_n = 1'($urandom_range(0, 3) == 0);
      rw   = 1'($urandom_range(0, 2) == 0);
      en_n = 1'($urandom_range(0, 1));
      ld_n = 1'($urandom_range(0, 3) != 0);
      addr = 4'($urandom_range(0, 15));
      din  = 8'($urandom_range(0, 255));
    end
    idle();
    @(negedge clk);
    @(negedge clk);
    #5;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule